// File: doc/BRIEF.md
# Serial BCD Real-Time Clock Register Slave

This block is the device end of a three-wire serial link: a chip-enable line, a serial clock and a single data line. The controller frames a transfer by raising chip enable, then shifts in a command byte that selects a register and picks read or write. On a write a data byte follows. On a read the device turns the data line around and shifts the selected byte back out. All three link signals are oversampled in the system clock domain, so the serial clock must run well below the system clock.

Behind the link sits a small register file. It holds a calendar clock in BCD (seconds, minutes, 24-hour hours, day of month, month, day of week and two-digit year), a write-protect control register, a trickle-charge setting register and a 32-byte scratch RAM. A one-cycle tick input advances the calendar by one second, unless the halt flag in the top bit of the seconds register is set. A separate combinational observation port lets the surrounding logic read any address without using the link.

Top module: `rtc_serial_slave`

## Requirements
- R1: After reset the registers hold: seconds 0x00, minutes 0x00, hours 0x00, day of month 0x01, month 0x01, day of week 0x01, year 0x00, control 0x80 (protected), trickle 0x00, and every scratch RAM byte 0x00.
- R2: A transfer starts when chip enable goes high. Bits are taken on the rising edges of the serial clock, least significant bit first. In the command byte, bit 0 = 1 selects read, bits 6:1 give the address and bit 7 is ignored. For a write command, the next 8 bits form the data byte, LSB first, and the write takes effect on the 16th rising edge.
- R3: For a read command, the data output is enabled on the first falling edge after the 8th rising edge. At that point it presents bit 0 of the addressed byte. Each later falling edge presents the next bit, and the output stays enabled until chip enable drops.
- R4: Address map: 0x00 seconds, 0x01 minutes, 0x02 hours, 0x03 day of month, 0x04 month, 0x05 day of week, 0x06 year, 0x07 control, 0x08 trickle, and 0x20–0x3F scratch RAM. A RAM byte reads back exactly as written. Any other address reads 0x00 and ignores writes. Written time values are masked: minutes 0x7F, hours 0x3F, day of month 0x3F, month 0x1F, day of week 0x07, seconds and year keep all 8 bits.
- R5: Bit 7 of the control register is write protect, and a write to control stores only that bit. While it is set, writes to every other address, RAM included, are ignored.
- R6: While bit 7 of seconds is 1, ticks leave every time register unchanged. Once it is cleared, ticks count again.
- R7: Each accepted tick adds one to seconds in BCD. 59 wraps to 00 with a carry into minutes, and minutes 59 wraps to 00 with a carry into hours. Hours count 00–23, and a wrap from 23 carries into the day.
- R8: The day of month wraps to 01 after the last day of the month and carries into the month. That last day is 31, or 30 for months 04, 06, 09 and 11, or for month 02 it is 29 when the year's decimal value is divisible by 4 and 28 otherwise. Month 12 wraps to 01 and carries into the year, and year 99 wraps to 00.
- R9: On every day carry the day of week goes up by one, and 7 wraps to 1.
- R10: A trickle write whose upper nibble is 0xA is stored as written. Any other value stores 0x00.
- R11: If chip enable drops during a transfer, the transfer is aborted: no register changes, the data output is released, and the next transfer decodes its command from bit 0 again.
- R12: The observation port returns, combinationally, the byte at its address under the same map as serial reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_ce_i | input | 1 | Serial chip enable, active high |
| ser_clk_i | input | 1 | Serial shift clock |
| ser_din_i | input | 1 | Serial data from controller |
| ser_dout_o | output | 1 | Serial data to controller |
| ser_dout_en_o | output | 1 | Output enable for the data line |
| tick_i | input | 1 | One-second pulse, one clock wide |
| obs_addr_i | input | 6 | Observation address |
| obs_data_o | output | 8 | Byte at the observation address |

## Verification
The bench uses the default parameters: a two-stage input synchronizer and a 32-byte RAM placed at 0x20, which fills the upper half of the 6-bit address space. Both ends of the RAM window and an unmapped address in between can therefore be reached with ordinary commands. Serial half-periods of eight system clocks leave enough room for the synchronizer latency. Since ticks are applied one at a time after setting the calendar through the link, each rollover case (non-leap and leap February, a 30-day month, year 99) is reached within a single tick.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int ADDR_W = 6;
  localparam int BYTE_W = 8;

  localparam logic [ADDR_W-1:0] A_SEC  = 6'h00;
  localparam logic [ADDR_W-1:0] A_MIN  = 6'h01;
  localparam logic [ADDR_W-1:0] A_HOUR = 6'h02;
  localparam logic [ADDR_W-1:0] A_DATE = 6'h03;
  localparam logic [ADDR_W-1:0] A_MON  = 6'h04;
  localparam logic [ADDR_W-1:0] A_DOW  = 6'h05;
  localparam logic [ADDR_W-1:0] A_YEAR = 6'h06;
  localparam logic [ADDR_W-1:0] A_CTRL = 6'h07;
  localparam logic [ADDR_W-1:0] A_TRKL = 6'h08;

  typedef struct packed {
    logic       wrap;
    logic [7:0] val;
  } bcd_step_t;

  // Advance a two-digit BCD value; at or beyond 'last' return to 'first'.
  function automatic bcd_step_t bcd_next(input logic [7:0] v,
                                         input logic [7:0] last,
                                         input logic [7:0] first);
    bcd_step_t r;
    r.wrap = 1'b0;
    if (v >= last) begin
      r.wrap = 1'b1;
      r.val  = first;
    end else if (v[3:0] >= 4'd9) begin
      r.val = {v[7:4] + 4'd1, 4'd0};
    end else begin
      r.val = {v[7:4], v[3:0] + 4'd1};
    end
    return r;
  endfunction

  function automatic logic [7:0] bcd_to_bin(input logic [7:0] b);
    return ({4'd0, b[7:4]} * 8'd10) + {4'd0, b[3:0]};
  endfunction

  function automatic logic year_is_leap(input logic [7:0] yr);
    logic [7:0] n;
    n = bcd_to_bin(yr);
    return n[1:0] == 2'b00;
  endfunction

  function automatic logic [7:0] month_end(input logic [7:0] mon,
                                           input logic [7:0] yr);
    logic [7:0] d;
    case (mon)
      8'h02:                      d = year_is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: d = 8'h30;
      default:                    d = 8'h31;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/rtc_in_sync.sv
module rtc_in_sync #(
  parameter int STAGES = 2,
  parameter int W      = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (STAGES == 0) begin : g_bypass
    assign q_o = d_i;
  end else begin : g_chain
    logic [W-1:0] stage_q [STAGES];
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= d_i;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
    assign q_o = stage_q[STAGES-1];
  end
endmodule

// File: rtl/rtc_link_engine.sv
module rtc_link_engine
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic [BYTE_W-1:0] rd_byte_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wr_stb_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              rd_load_o,
  output logic              sdo_o,
  output logic              sdo_en_o
);
  localparam int CNT_W = $clog2(2*BYTE_W + 1);
  localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] CMD_DONE  = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(2*BYTE_W - 1);
  localparam logic [CNT_W-1:0] FULL      = CNT_W'(2*BYTE_W);

  logic              sclk_d;
  logic              sclk_rise, sclk_fall;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-2:0] cmd_q;
  logic [BYTE_W-2:0] dat_q;
  logic [BYTE_W-1:0] out_q;
  logic              oe_q;
  logic              is_read;

  assign sclk_rise = sclk_i & ~sclk_d;
  assign sclk_fall = ~sclk_i & sclk_d;
  assign is_read   = cmd_q[0];
  assign addr_o    = cmd_q[BYTE_W-2:1];

  assign wr_stb_o  = ce_i && sclk_rise && (bit_cnt == DATA_LAST) && !is_read;
  assign wr_data_o = {sdi_i, dat_q};
  assign rd_load_o = ce_i && sclk_fall && (bit_cnt == CMD_DONE) && is_read && !oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d  <= 1'b0;
      bit_cnt <= '0;
      cmd_q   <= '0;
      dat_q   <= '0;
      out_q   <= '0;
      oe_q    <= 1'b0;
    end else begin
      sclk_d <= sclk_i;
      if (!ce_i) begin
        bit_cnt <= '0;
        cmd_q   <= '0;
        oe_q    <= 1'b0;
      end else begin
        if (sclk_rise && bit_cnt != FULL) begin
          if (bit_cnt < CMD_LAST)
            cmd_q[bit_cnt[2:0]] <= sdi_i;
          else if (bit_cnt >= CMD_DONE && bit_cnt < DATA_LAST)
            dat_q[bit_cnt[2:0]] <= sdi_i;
          bit_cnt <= bit_cnt + 1'b1;
        end
        if (rd_load_o) begin
          out_q <= rd_byte_i;
          oe_q  <= 1'b1;
        end else if (sclk_fall && oe_q) begin
          out_q <= {1'b0, out_q[BYTE_W-1:1]};
        end
      end
    end
  end

  assign sdo_o    = out_q[0];
  assign sdo_en_o = oe_q;
endmodule

// File: rtl/rtc_regbank.sv
module rtc_regbank
  import rtc_pkg::*;
#(
  parameter int RAM_BASE  = 32,
  parameter int RAM_DEPTH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_stb_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [BYTE_W-1:0] rd_data_o,
  input  logic [ADDR_W-1:0] obs_addr_i,
  output logic [BYTE_W-1:0] obs_data_o,
  output logic              wp_o,
  output logic [BYTE_W-1:0] sec_o,
  output logic [BYTE_W-1:0] year_o
);
  localparam int RAM_AW = (RAM_DEPTH > 1) ? $clog2(RAM_DEPTH) : 1;
  localparam logic [ADDR_W:0] RAM_LO = (ADDR_W+1)'(RAM_BASE);
  localparam logic [ADDR_W:0] RAM_HI = (ADDR_W+1)'(RAM_BASE + RAM_DEPTH);

  logic [7:0] sec_q, min_q, hour_q, date_q, mon_q, dow_q, year_q, ctrl_q, trkl_q;
  logic [7:0] ram_q [RAM_DEPTH];

  // Named internal events
  logic      wp, halted, tick_adv, wr_accept;
  logic      carry_min, carry_hour, day_carry, carry_mon, carry_year;
  logic      wr_in_ram;
  logic [RAM_AW-1:0] wr_off;
  bcd_step_t s_nx, m_nx, h_nx, d_nx, mo_nx, y_nx, w_nx;

  assign wp        = ctrl_q[7];
  assign halted    = sec_q[7];
  assign tick_adv  = tick_i && !halted;
  assign wr_accept = wr_stb_i && (!wp || wr_addr_i == A_CTRL);
  assign wr_in_ram = ({1'b0, wr_addr_i} >= RAM_LO) && ({1'b0, wr_addr_i} < RAM_HI);
  assign wr_off    = RAM_AW'(wr_addr_i - ADDR_W'(RAM_BASE));

  always_comb begin
    s_nx  = bcd_next({1'b0, sec_q[6:0]}, 8'h59, 8'h00);
    m_nx  = bcd_next(min_q, 8'h59, 8'h00);
    h_nx  = bcd_next(hour_q, 8'h23, 8'h00);
    d_nx  = bcd_next(date_q, month_end(mon_q, year_q), 8'h01);
    mo_nx = bcd_next(mon_q, 8'h12, 8'h01);
    y_nx  = bcd_next(year_q, 8'h99, 8'h00);
    w_nx  = bcd_next(dow_q, 8'h07, 8'h01);
  end

  assign carry_min  = tick_adv && s_nx.wrap;
  assign carry_hour = carry_min && m_nx.wrap;
  assign day_carry  = carry_hour && h_nx.wrap;
  assign carry_mon  = day_carry && d_nx.wrap;
  assign carry_year = carry_mon && mo_nx.wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q  <= 8'h00;
      min_q  <= 8'h00;
      hour_q <= 8'h00;
      date_q <= 8'h01;
      mon_q  <= 8'h01;
      dow_q  <= 8'h01;
      year_q <= 8'h00;
      ctrl_q <= 8'h80;
      trkl_q <= 8'h00;
      for (int i = 0; i < RAM_DEPTH; i++) ram_q[i] <= 8'h00;
    end else begin
      if (tick_adv)   sec_q  <= s_nx.val;
      if (carry_min)  min_q  <= m_nx.val;
      if (carry_hour) hour_q <= h_nx.val;
      if (day_carry) begin
        date_q <= d_nx.val;
        dow_q  <= w_nx.val;
      end
      if (carry_mon)  mon_q  <= mo_nx.val;
      if (carry_year) year_q <= y_nx.val;
      // An accepted write overrides the tick update of its own register.
      if (wr_accept) begin
        if (wr_in_ram) begin
          ram_q[wr_off] <= wr_data_i;
        end else begin
          case (wr_addr_i)
            A_SEC:  sec_q  <= wr_data_i;
            A_MIN:  min_q  <= wr_data_i & 8'h7F;
            A_HOUR: hour_q <= wr_data_i & 8'h3F;
            A_DATE: date_q <= wr_data_i & 8'h3F;
            A_MON:  mon_q  <= wr_data_i & 8'h1F;
            A_DOW:  dow_q  <= wr_data_i & 8'h07;
            A_YEAR: year_q <= wr_data_i;
            A_CTRL: ctrl_q <= {wr_data_i[7], 7'd0};
            A_TRKL: trkl_q <= (wr_data_i[7:4] == 4'hA) ? wr_data_i : 8'h00;
            default: ;
          endcase
        end
      end
    end
  end

  // Two identical read ports: serial read and observation.
  logic [1:0][ADDR_W-1:0] port_addr;
  assign port_addr = {obs_addr_i, rd_addr_i};

  for (genvar p = 0; p < 2; p++) begin : g_rport
    logic [BYTE_W-1:0] val;
    logic [RAM_AW-1:0] off;
    logic              in_ram;
    assign in_ram = ({1'b0, port_addr[p]} >= RAM_LO) && ({1'b0, port_addr[p]} < RAM_HI);
    assign off    = RAM_AW'(port_addr[p] - ADDR_W'(RAM_BASE));
    always_comb begin
      val = 8'h00;
      if (in_ram) begin
        val = ram_q[off];
      end else begin
        case (port_addr[p])
          A_SEC:  val = sec_q;
          A_MIN:  val = min_q;
          A_HOUR: val = hour_q;
          A_DATE: val = date_q;
          A_MON:  val = mon_q;
          A_DOW:  val = dow_q;
          A_YEAR: val = year_q;
          A_CTRL: val = ctrl_q;
          A_TRKL: val = trkl_q;
          default: val = 8'h00;
        endcase
      end
    end
  end

  assign rd_data_o  = g_rport[0].val;
  assign obs_data_o = g_rport[1].val;
  assign wp_o       = wp;
  assign sec_o      = sec_q;
  assign year_o     = year_q;
endmodule

// File: rtl/rtc_serial_slave.sv
module rtc_serial_slave
  import rtc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RAM_BASE    = 32,
  parameter int RAM_DEPTH   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_ce_i,
  input  logic              ser_clk_i,
  input  logic              ser_din_i,
  output logic              ser_dout_o,
  output logic              ser_dout_en_o,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] obs_addr_i,
  output logic [BYTE_W-1:0] obs_data_o
);
  logic              ce_s, sclk_s, sdi_s;
  logic [ADDR_W-1:0] xfer_addr;
  logic              wr_stb, rd_load, wp;
  logic [BYTE_W-1:0] wr_data, rd_byte, sec_view, year_view;

  rtc_in_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({ser_ce_i, ser_clk_i, ser_din_i}),
    .q_o   ({ce_s, sclk_s, sdi_s})
  );

  rtc_link_engine u_link (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_i      (ce_s),
    .sclk_i    (sclk_s),
    .sdi_i     (sdi_s),
    .rd_byte_i (rd_byte),
    .addr_o    (xfer_addr),
    .wr_stb_o  (wr_stb),
    .wr_data_o (wr_data),
    .rd_load_o (rd_load),
    .sdo_o     (ser_dout_o),
    .sdo_en_o  (ser_dout_en_o)
  );

  rtc_regbank #(.RAM_BASE(RAM_BASE), .RAM_DEPTH(RAM_DEPTH)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .wr_stb_i   (wr_stb),
    .wr_addr_i  (xfer_addr),
    .wr_data_i  (wr_data),
    .rd_addr_i  (xfer_addr),
    .rd_data_o  (rd_byte),
    .obs_addr_i (obs_addr_i),
    .obs_data_o (obs_data_o),
    .wp_o       (wp),
    .sec_o      (sec_view),
    .year_o     (year_view)
  );
endmodule

// File: rtl/rtc_serial_slave_chk.sv
module rtc_serial_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ce_s,
  input logic       sdo_en,
  input logic       wr_stb,
  input logic       rd_load,
  input logic [5:0] wr_addr,
  input logic       wp,
  input logic [7:0] sec_q,
  input logic [7:0] year_q,
  input logic       tick_i
);
  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_stb, rd_load})); // R2

  AST_OE_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_en) |-> $past(rd_load)); // R3

  AST_WP_KEEPS_YEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wp && wr_stb && wr_addr == 6'h06 && !tick_i) |=> $stable(year_q)); // R5

  AST_HALT_HOLDS_SEC: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_q[7] && !wr_stb) |=> $stable(sec_q)); // R6

  AST_TICK_STEPS_UNITS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !sec_q[7] && !wr_stb && sec_q[3:0] < 4'd9 && sec_q[6:4] <= 3'd5)
      |=> sec_q[3:0] == $past(sec_q[3:0]) + 4'd1); // R7

  AST_NO_DRIVE_WITHOUT_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_s |=> !sdo_en); // R11
endmodule

bind rtc_serial_slave rtc_serial_slave_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ce_s    (ce_s),
  .sdo_en  (ser_dout_en_o),
  .wr_stb  (wr_stb),
  .rd_load (rd_load),
  .wr_addr (xfer_addr),
  .wp      (wp),
  .sec_q   (sec_view),
  .year_q  (year_view),
  .tick_i  (tick_i)
);

// File: tb/rtc_serial_slave_test.sv
module rtc_serial_slave_test;
  localparam int H  = 8;       // serial half period in system clocks
  localparam int WD = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce = 1'b0, sclk = 1'b0, sdi = 1'b0, tick = 1'b0;
  logic       sdo, sdo_en;
  logic [5:0] obs_addr = 6'h00;
  logic [7:0] obs_data;

  int  n_run = 0, n_fail = 0;
  bit  done = 1'b0;
  logic [7:0] exp_q [$];
  logic [7:0] act_q [$];
  string      tag_q [$];

  always #10 clk = ~clk;

  rtc_serial_slave uut (
    .clk (clk), .rst_n (rst_n),
    .ser_ce_i (ce), .ser_clk_i (sclk), .ser_din_i (sdi),
    .ser_dout_o (sdo), .ser_dout_en_o (sdo_en),
    .tick_i (tick), .obs_addr_i (obs_addr), .obs_data_o (obs_data)
  );

  // Monitor: pairs each produced result with the expectation queued first.
  initial begin
    forever begin
      @(negedge clk);
      while (act_q.size() > 0 && exp_q.size() > 0) begin
        logic [7:0] e, a;
        string t;
        e = exp_q.pop_front(); a = act_q.pop_front(); t = tag_q.pop_front();
        n_run++;
        if (a !== e) begin
          n_fail++;
          $display("FAIL %s actual=%02h expected=%02h", t, a, e);
        end
      end
    end
  end

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_item(input logic [7:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
  endtask

  task automatic send_bit(input logic b);
    sdi = b; clks(H); sclk = 1'b1; clks(H); sclk = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
  endtask

  task automatic open_xfer;
    ce = 1'b1; clks(H);
  endtask

  task automatic close_xfer;
    clks(H); ce = 1'b0; clks(H);
  endtask

  task automatic reg_write(input logic [5:0] a, input logic [7:0] d);
    open_xfer; send_byte({1'b1, a, 1'b0}); send_byte(d); close_xfer;
  endtask

  task automatic reg_read(input logic [5:0] a, input logic [7:0] e, input string t);
    logic [7:0] v;
    logic       en_all;
    expect_item(e, t);
    expect_item(8'h01, "R3 output enabled during read");
    open_xfer; send_byte({1'b1, a, 1'b1});
    v = 8'h00; en_all = 1'b1;
    for (int i = 0; i < 8; i++) begin
      clks(H); v[i] = sdo; en_all = en_all & sdo_en;
      sclk = 1'b1; clks(H); sclk = 1'b0;
    end
    close_xfer;
    act_q.push_back(v);
    act_q.push_back({7'd0, en_all});
  endtask

  task automatic obs_check(input logic [5:0] a, input logic [7:0] e, input string t);
    expect_item(e, t);
    obs_addr = a; clks(1);
    act_q.push_back(obs_data);
  endtask

  task automatic one_tick;
    tick = 1'b1; clks(1); tick = 1'b0; clks(1);
  endtask

  task automatic set_cal(input logic [7:0] s, m, h, d, mo, w, y);
    reg_write(6'h00, s); reg_write(6'h01, m); reg_write(6'h02, h);
    reg_write(6'h03, d); reg_write(6'h04, mo); reg_write(6'h05, w);
    reg_write(6'h06, y);
  endtask

  task automatic check_cal(input logic [7:0] s, m, h, d, mo, w, y, input string t);
    obs_check(6'h00, s, t); obs_check(6'h01, m, t); obs_check(6'h02, h, t);
    obs_check(6'h03, d, t); obs_check(6'h04, mo, t); obs_check(6'h05, w, t);
    obs_check(6'h06, y, t);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      summary;
      $finish;
    end
  end

  initial begin
    clks(3); rst_n = 1'b1; clks(3);

    // R1 reset state, read through the observation port (R12)
    check_cal(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, "R1 reset time");
    obs_check(6'h07, 8'h80, "R1 reset control");
    obs_check(6'h08, 8'h00, "R1 reset trickle");
    obs_check(6'h20, 8'h00, "R1 reset ram");
    expect_item(8'h00, "R3 idle output disabled"); act_q.push_back({7'd0, sdo_en});

    // R5 write protect active from reset
    reg_write(6'h01, 8'h33);
    obs_check(6'h01, 8'h00, "R5 protected write ignored");
    reg_write(6'h20, 8'h55);
    obs_check(6'h20, 8'h00, "R5 protected ram write ignored");
    reg_write(6'h07, 8'hFF);
    reg_read(6'h07, 8'h80, "R5 control keeps only bit 7");
    reg_write(6'h07, 8'h00);
    obs_check(6'h07, 8'h00, "R5 protect cleared");

    // R2 R3 R4 scratch RAM and map
    reg_write(6'h20, 8'h42);
    reg_read(6'h20, 8'h42, "R4 ram low end");
    reg_write(6'h3F, 8'h99);
    reg_read(6'h3F, 8'h99, "R4 ram high end");
    obs_check(6'h3F, 8'h99, "R12 observation matches serial read");
    reg_write(6'h10, 8'h77);
    reg_read(6'h10, 8'h00, "R4 unmapped address");
    reg_write(6'h01, 8'hFF);
    obs_check(6'h01, 8'h7F, "R4 minutes mask");
    reg_write(6'h05, 8'hFE);
    obs_check(6'h05, 8'h06, "R4 weekday mask");
    reg_write(6'h0A, 8'hA5);
    reg_read(6'h08, 8'h00, "R2 address bits select register");

    // R10 trickle
    reg_write(6'h08, 8'hA5);
    reg_read(6'h08, 8'hA5, "R10 trickle enable value");
    reg_write(6'h08, 8'h35);
    obs_check(6'h08, 8'h00, "R10 trickle other value");

    // R11 aborts
    reg_write(6'h21, 8'h11);
    open_xfer; send_byte({1'b1, 6'h21, 1'b0});
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    close_xfer;
    obs_check(6'h21, 8'h11, "R11 aborted write leaves ram");
    open_xfer; send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); close_xfer;
    reg_read(6'h20, 8'h42, "R11 counter restarts after abort");
    open_xfer; send_byte({1'b1, 6'h20, 1'b1}); clks(H);
    expect_item(8'h01, "R3 enable during partial read"); act_q.push_back({7'd0, sdo_en});
    ce = 1'b0; clks(H);
    expect_item(8'h00, "R11 output released on abort"); act_q.push_back({7'd0, sdo_en});

    // R6 halt
    reg_write(6'h00, 8'h85);
    one_tick; one_tick; one_tick;
    obs_check(6'h00, 8'h85, "R6 halted seconds hold");
    reg_write(6'h00, 8'h05);
    one_tick;
    obs_check(6'h00, 8'h06, "R6 counting resumes");

    // R7 BCD carries
    reg_write(6'h00, 8'h09);
    one_tick;
    obs_check(6'h00, 8'h10, "R7 units carry");
    reg_write(6'h00, 8'h59); reg_write(6'h01, 8'h12);
    one_tick;
    obs_check(6'h00, 8'h00, "R7 seconds wrap");
    obs_check(6'h01, 8'h13, "R7 minute carry");
    set_cal(8'h59, 8'h59, 8'h09, 8'h14, 8'h05, 8'h02, 8'h31);
    one_tick;
    check_cal(8'h00, 8'h00, 8'h10, 8'h14, 8'h05, 8'h02, 8'h31, "R7 hour carry");

    // R8 R9 calendar rollovers
    set_cal(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h07, 8'h23);
    one_tick;
    check_cal(8'h00, 8'h00, 8'h00, 8'h01, 8'h03, 8'h01, 8'h23, "R8 R9 non-leap february");
    set_cal(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h04, 8'h24);
    one_tick;
    check_cal(8'h00, 8'h00, 8'h00, 8'h29, 8'h02, 8'h05, 8'h24, "R8 leap day");
    reg_write(6'h00, 8'h59); reg_write(6'h01, 8'h59); reg_write(6'h02, 8'h23);
    one_tick;
    check_cal(8'h00, 8'h00, 8'h00, 8'h01, 8'h03, 8'h06, 8'h24, "R8 after leap day");
    set_cal(8'h59, 8'h59, 8'h23, 8'h30, 8'h04, 8'h02, 8'h50);
    one_tick;
    check_cal(8'h00, 8'h00, 8'h00, 8'h01, 8'h05, 8'h03, 8'h50, "R8 thirty-day month");
    set_cal(8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h03, 8'h99);
    one_tick;
    check_cal(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h04, 8'h00, "R8 R9 year rollover");

    // R5 protect re-enabled after setting time
    reg_write(6'h07, 8'h80);
    reg_write(6'h06, 8'h42);
    obs_check(6'h06, 8'h00, "R5 year protected");

    clks(4);
    done = 1'b1;
    summary;
    $finish;
  end
endmodule